// File: doc/BRIEF.md
# Memory-Mapped Keyboard Input Port

This block is the receive side of a keyboard attached to a 16-bit processor. The processor sees it as two registers in its memory space. A status word sits at address 0xFE00 and a character word sits at 0xFE02. On the device side, an 8-bit character code arrives with a strobe that lasts one clock cycle. The block holds exactly one character until the processor collects it.

On the processor side, the block decodes the load address combinationally. It returns the register contents on the same cycle as the read. It also raises a hit flag, so the datapath loads the memory data register from the device instead of from memory. Reading the character word consumes the character: the ready flag drops at the next clock edge and the keyboard is accepted again. Keystrokes that arrive while a character is still unread are thrown away.

Top module: `kbd_input_port`

## Requirements
- R1: A read at address 0xFE00 returns the ready flag in bit 15, with bits 14..0 at zero.
- R2: A read at address 0xFE02 returns the held character in bits 7..0, with bits 15..8 at zero.
- R3: A strobe on `key_valid_i` while the ready flag is clear stores `key_code_i`. From the next cycle the ready flag reads 1 and the character word returns that code.
- R4: A strobe while the ready flag is set is discarded. The held character and the flag stay unchanged.
- R5: A read at 0xFE02 clears the ready flag at the next clock edge.
- R6: A read at 0xFE00 leaves the ready flag and the character unchanged.
- R7: A strobe in the same cycle as a read at 0xFE02 is captured. That read returns the old character, and afterwards the flag is set with the new code.
- R8: A write (`wr_en_i`) to either address changes neither the flag nor the character.
- R9: `hit_o` is 1 only when `rd_en_i` is high and the address is 0xFE00 or 0xFE02. Otherwise `hit_o` is 0 and `rd_data_o` is zero.
- R10: Reset (`rst_ni` low, asynchronous) clears the ready flag and the held character to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_valid_i | input | 1 | One-cycle strobe marking a new character |
| key_code_i | input | 8 | Character code, valid with the strobe |
| addr_i | input | 16 | Processor load/store address |
| rd_en_i | input | 1 | Processor read enable |
| wr_en_i | input | 1 | Processor write enable |
| wr_data_i | input | 16 | Processor write data (ignored) |
| rd_data_o | output | 16 | Register read data, combinational |
| hit_o | output | 1 | Address selects a device register on a read |

## Verification
The assertions assume that `key_code_i` is meaningful only while `key_valid_i` is high. They also assume that the address is stable for the whole cycle in which it is sampled. The bench changes every input only on the falling clock edge, so each rising edge sees settled values. The bench drives the strobe and a data-register read together only in deliberate cases, and it places reads and writes at unmapped addresses next to live traffic, which checks that decoding is exact.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int unsigned ADDR_W      = 16;
  localparam int unsigned DATA_W      = 16;
  localparam int unsigned CHAR_W      = 8;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = 16'hFE00;
  localparam logic [ADDR_W-1:0] CHAR_ADDR   = 16'hFE02;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_CHAR   = 2'd2
  } kbd_sel_e;
endpackage

// File: rtl/kbd_addr_decode.sv
module kbd_addr_decode
  import kbd_pkg::*;
#(
  parameter int unsigned ADDR_W = kbd_pkg::ADDR_W,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = kbd_pkg::STATUS_ADDR,
  parameter logic [ADDR_W-1:0] CHAR_ADDR   = kbd_pkg::CHAR_ADDR
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_en_i,
  output kbd_sel_e          sel_o,
  output logic              hit_o,
  output logic              consume_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (rd_en_i) begin
      if (addr_i == STATUS_ADDR)    sel_o = SEL_STATUS;
      else if (addr_i == CHAR_ADDR) sel_o = SEL_CHAR;
    end
  end

  assign hit_o     = (sel_o != SEL_NONE);
  assign consume_o = (sel_o == SEL_CHAR);
endmodule

// File: rtl/kbd_char_hold.sv
module kbd_char_hold #(
  parameter int unsigned CHAR_W = kbd_pkg::CHAR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_valid_i,
  input  logic [CHAR_W-1:0] key_code_i,
  input  logic              consume_i,
  output logic              ready_o,
  output logic [CHAR_W-1:0] char_o
);
  logic accept;
  // consume frees the slot in the same cycle, so a coincident key lands
  assign accept = key_valid_i && (!ready_o || consume_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o <= 1'b0;
      char_o  <= '0;
    end else begin
      if (accept) begin
        ready_o <= 1'b1;
        char_o  <= key_code_i;
      end else if (consume_i) begin
        ready_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/kbd_read_mux.sv
module kbd_read_mux
  import kbd_pkg::*;
#(
  parameter int unsigned DATA_W = kbd_pkg::DATA_W,
  parameter int unsigned CHAR_W = kbd_pkg::CHAR_W
) (
  input  kbd_sel_e          sel_i,
  input  logic              ready_i,
  input  logic [CHAR_W-1:0] char_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned PAD_W  = DATA_W - CHAR_W;
  localparam int unsigned FLAG_B = DATA_W - 1;

  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] char_word;

  always_comb begin
    status_word         = '0;
    status_word[FLAG_B] = ready_i;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign char_word = {{PAD_W{1'b0}}, char_i};
    end else begin : g_nopad
      assign char_word = char_i[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (sel_i)
      SEL_STATUS: rd_data_o = status_word;
      SEL_CHAR:   rd_data_o = char_word;
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/kbd_input_port.sv
module kbd_input_port
  import kbd_pkg::*;
#(
  parameter int unsigned ADDR_W = kbd_pkg::ADDR_W,
  parameter int unsigned DATA_W = kbd_pkg::DATA_W,
  parameter int unsigned CHAR_W = kbd_pkg::CHAR_W,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = kbd_pkg::STATUS_ADDR,
  parameter logic [ADDR_W-1:0] CHAR_ADDR   = kbd_pkg::CHAR_ADDR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_valid_i,
  input  logic [CHAR_W-1:0] key_code_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              hit_o
);
  kbd_sel_e          sel;
  logic              consume;
  logic              ready_q;
  logic [CHAR_W-1:0] char_q;

  // writes are decoded nowhere: both registers are read-only
  logic unused_wr;
  assign unused_wr = wr_en_i ^ (^wr_data_i);

  kbd_addr_decode #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .CHAR_ADDR(CHAR_ADDR)
  ) u_dec (
    .addr_i(addr_i), .rd_en_i(rd_en_i),
    .sel_o(sel), .hit_o(hit_o), .consume_o(consume)
  );

  kbd_char_hold #(.CHAR_W(CHAR_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .key_valid_i(key_valid_i), .key_code_i(key_code_i),
    .consume_i(consume), .ready_o(ready_q), .char_o(char_q)
  );

  kbd_read_mux #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_mux (
    .sel_i(sel), .ready_i(ready_q), .char_i(char_q), .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/kbd_input_port_chk.sv
module kbd_input_port_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHAR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'hFE00,
  parameter logic [ADDR_W-1:0] CHAR_ADDR   = 16'hFE02
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              key_valid_i,
  input logic [CHAR_W-1:0] key_code_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              hit_o,
  input logic              ready_q,
  input logic [CHAR_W-1:0] char_q
);
  logic rd_stat, rd_char;
  assign rd_stat = rd_en_i && (addr_i == STATUS_ADDR);
  assign rd_char = rd_en_i && (addr_i == CHAR_ADDR);

  a_r1_status_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat |-> (rd_data_o[DATA_W-1] == ready_q) && (rd_data_o[DATA_W-2:0] == '0));

  a_r2_char_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_char |-> (rd_data_o[CHAR_W-1:0] == char_q) && (rd_data_o[DATA_W-1:CHAR_W] == '0));

  a_r3_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_i && !ready_q) |=> ready_q && (char_q == $past(key_code_i)));

  a_r4_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_i && ready_q && !rd_char) |=> ready_q && $stable(char_q));

  a_r5_consume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_char && !key_valid_i) |=> !ready_q);

  a_r6_status_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_q && rd_stat && !key_valid_i) |=> ready_q && $stable(char_q));

  a_r7_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_char && key_valid_i) |=> ready_q && (char_q == $past(key_code_i)));

  a_r8_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_en_i && !key_valid_i) |=> $stable(ready_q) && $stable(char_q));

  a_r9_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_stat || rd_char) |-> !hit_o && (rd_data_o == '0));
endmodule

bind kbd_input_port kbd_input_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W),
  .STATUS_ADDR(STATUS_ADDR), .CHAR_ADDR(CHAR_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .key_valid_i(key_valid_i),
  .key_code_i(key_code_i), .addr_i(addr_i), .rd_en_i(rd_en_i),
  .wr_en_i(wr_en_i), .rd_data_o(rd_data_o), .hit_o(hit_o),
  .ready_q(ready_q), .char_q(char_q)
);

// File: tb/tb_kbd_input_port.sv
module tb_kbd_input_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        key_valid_i = 1'b0;
  logic [7:0]  key_code_i = '0;
  logic [15:0] addr_i = '0;
  logic        rd_en_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        hit_o;

  int checks = 0;
  int errors = 0;
  bit ref_ready = 0;
  int ref_char = 0;

  always #4 clk_i = ~clk_i;

  kbd_input_port dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .key_valid_i(key_valid_i),
    .key_code_i(key_code_i), .addr_i(addr_i), .rd_en_i(rd_en_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .hit_o(hit_o)
  );

  function automatic logic [16:0] expect_out(input logic rd, input logic [15:0] a);
    logic h;
    logic [15:0] d;
    h = rd && (a == 16'hFE00 || a == 16'hFE02);
    d = 16'h0;
    if (h && a == 16'hFE00) d = ref_ready ? 16'h8000 : 16'h0;
    if (h && a == 16'hFE02) d = 16'(ref_char);
    return {h, d};
  endfunction

  task automatic check(input string tag);
    logic [16:0] exp_v;
    exp_v = expect_out(rd_en_i, addr_i);
    checks++;
    if ({hit_o, rd_data_o} !== exp_v) begin
      errors++;
      $display("FAIL %s addr=%h rd=%0b: got hit=%0b data=%h, expected hit=%0b data=%h",
               tag, addr_i, rd_en_i, hit_o, rd_data_o, exp_v[16], exp_v[15:0]);
    end
  endtask

  // one clock: drive on falling edge, check, then advance the model past the rising edge
  task automatic step(input bit kv, input logic [7:0] kc, input logic [15:0] a,
                      input bit rd, input bit wr, input logic [15:0] wd, input string tag);
    @(negedge clk_i);
    key_valid_i = kv; key_code_i = kc; addr_i = a;
    rd_en_i = rd; wr_en_i = wr; wr_data_i = wd;
    #1 check(tag);
    @(posedge clk_i);
    if (rd && a == 16'hFE02) ref_ready = 0;
    if (kv && !ref_ready) begin
      ref_ready = 1;
      ref_char  = int'(kc);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10: outputs under reset
    #2 addr_i = 16'hFE00; rd_en_i = 1'b1;
    #1 check("R10");
    repeat (2) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    step(0, 8'h00, 16'hFE00, 1, 0, 0, "R10");
    step(0, 8'h00, 16'hFE02, 1, 0, 0, "R10");
    // R3 capture
    step(1, 8'h41, 16'h0000, 0, 0, 0, "R3");
    step(0, 8'h00, 16'hFE00, 1, 0, 0, "R3");
    // R4 drop while ready
    step(1, 8'h42, 16'h0000, 0, 0, 0, "R4");
    step(0, 8'h00, 16'hFE02, 1, 0, 0, "R4");
    // R5 consumed
    step(0, 8'h00, 16'hFE00, 1, 0, 0, "R5");
    step(0, 8'h00, 16'hFE02, 1, 0, 0, "R5");
    // R6 status reads keep state
    step(1, 8'h43, 16'h0000, 0, 0, 0, "R6");
    step(0, 8'h00, 16'hFE00, 1, 0, 0, "R6");
    step(0, 8'h00, 16'hFE00, 1, 0, 0, "R6");
    // R7 read and strobe together
    step(1, 8'h44, 16'hFE02, 1, 0, 0, "R7");
    step(0, 8'h00, 16'hFE00, 1, 0, 0, "R7");
    step(0, 8'h00, 16'hFE02, 1, 0, 0, "R7");
    // R8 writes inert
    step(1, 8'h45, 16'h0000, 0, 0, 0, "R8");
    step(0, 8'h00, 16'hFE00, 0, 1, 16'h0000, "R8");
    step(0, 8'h00, 16'hFE02, 0, 1, 16'h1234, "R8");
    step(0, 8'h00, 16'hFE00, 1, 0, 0, "R8");
    step(0, 8'h00, 16'hFE02, 0, 1, 16'hFFFF, "R8");
    step(0, 8'h00, 16'hFE02, 1, 0, 0, "R8");
    // R9 decode
    step(1, 8'h46, 16'hFE04, 1, 0, 0, "R9");
    step(0, 8'h00, 16'hFE00, 0, 0, 0, "R9");
    step(0, 8'h00, 16'hFE03, 1, 0, 0, "R9");
    step(0, 8'h00, 16'h7E00, 1, 0, 0, "R9");
    step(0, 8'h00, 16'hFE00, 1, 0, 0, "R1");
    step(0, 8'h00, 16'hFE02, 1, 0, 0, "R2");
    // mixed traffic
    for (int i = 0; i < 200; i++) begin
      logic [1:0] s;
      logic [15:0] a;
      string t;
      s = 2'($urandom_range(0, 3));
      a = (s == 0) ? 16'hFE00 : (s == 1) ? 16'hFE02 : (s == 2) ? 16'hFE06 : 16'($urandom);
      t = (s == 0) ? "R1" : (s == 1) ? "R2" : "R9";
      step(bit'($urandom_range(0, 1)), 8'($urandom), a, bit'($urandom_range(0, 1)),
           bit'($urandom_range(0, 1)), 16'($urandom), t);
    end
    // R10 asynchronous reset in mid-run
    step(1, 8'h5A, 16'h0000, 0, 0, 0, "R10");
    @(negedge clk_i);
    key_valid_i = 0; rd_en_i = 0; wr_en_i = 0;
    #1 rst_ni = 1'b0;
    ref_ready = 0; ref_char = 0;
    #2 addr_i = 16'hFE02; rd_en_i = 1'b1;
    #1 check("R10");
    @(negedge clk_i) rst_ni = 1'b1;
    step(0, 8'h00, 16'hFE00, 1, 0, 0, "R10");
    step(0, 8'h00, 16'hFE02, 1, 0, 0, "R10");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule